// File: doc/BRIEF.md
# Host Data Port with Protected FIFOs

This block places one host-facing data register in front of two byte queues. A host write enqueues a byte toward the serial side (the transmit queue). A host read dequeues a byte that the serial side has delivered (the receive queue). The serial side drains the transmit queue and fills the receive queue through its own pop and push strobes. Both queues are first-word-fall-through, so the head byte is always visible at the output.

The host can make two illegal accesses: writing while the transmit queue is full, and reading while the receive queue is empty. Neither access moves any pointer. A write to a full queue is dropped. A read from an empty queue returns the byte that the last good read returned.

Each illegal access produces a one-cycle error pulse, intended for interrupt status logic. It also sets a sticky error flag. The host clears the flag by writing a clear strobe with its data bit at 1.

Top module: `fifo_data_port`

## Requirements
- R1: A host write (`host_wr_en`=1) while `tx_full`=0 appends `host_wr_data` to the transmit queue. `tx_data` always shows the oldest stored byte, and bytes leave through `tx_pop` in write order.
- R2: A host write while `tx_full`=1 is dropped. The queue contents and order stay unchanged.
- R3: A host read (`host_rd_en`=1) while `rx_empty`=0 removes the oldest receive byte. That byte appears on `host_rd_data` from the next cycle on and stays there until the next successful read.
- R4: A host read while `rx_empty`=1 leaves `host_rd_data` at its previous value and removes nothing. `host_rd_data` is 0x00 after reset.
- R5: `acc_err_pulse` is 1 for exactly the one cycle after any cycle that holds an illegal host access (R2 or R4), and is 0 otherwise. A cycle with both kinds of illegal access gives one pulse.
- R6: `acc_err_flag` resets to 0 and becomes 1 together with each error pulse. It returns to 0 only in the cycle after `err_clr_wr`=1 with `err_clr_bit`=1. A clear with `err_clr_bit`=0 has no effect. A new error in the same cycle as a clear wins, and the flag stays 1.
- R7: Each queue holds 8 bytes. After reset both queues are empty (`tx_empty`=`rx_empty`=1, `tx_full`=`rx_full`=0). A full flag is 1 exactly when 8 bytes are held, and a full flag and its empty flag are never both 1.
- R8: A legal push and a legal pop on the same queue in the same cycle are both performed. The byte count is unchanged and no byte is lost or duplicated.
- R9: A `tx_pop` while `tx_empty`=1, or an `rx_push` while `rx_full`=1, is ignored and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe to the data register |
| host_wr_data | input | 8 | Host write byte |
| host_rd_en | input | 1 | Host read strobe from the data register |
| host_rd_data | output | 8 | Byte held from the last successful host read |
| err_clr_wr | input | 1 | Host write strobe to the error-clear bit |
| err_clr_bit | input | 1 | Data bit of that write; 1 clears the flag |
| acc_err_pulse | output | 1 | One-cycle pulse after an illegal host access |
| acc_err_flag | output | 1 | Sticky access-error flag |
| tx_pop | input | 1 | Serial-side pop of the transmit queue |
| tx_data | output | 8 | Head byte of the transmit queue |
| tx_full | output | 1 | Transmit queue holds 8 bytes |
| tx_empty | output | 1 | Transmit queue holds no byte |
| rx_push | input | 1 | Serial-side push into the receive queue |
| rx_data | input | 8 | Byte pushed into the receive queue |
| rx_full | output | 1 | Receive queue holds 8 bytes |
| rx_empty | output | 1 | Receive queue holds no byte |

## Verification
The bench uses the default parameters: 8-bit data and a 3-bit address, which gives 8-entry queues. With so few entries, a handful of back-to-back writes or pushes reaches the full state, and a few reads reach the empty state. The random phases therefore cross both boundaries many times, with legal and illegal accesses on both sides mixed in. Directed sequences cover overflow of a full transmit queue, repeated reads of an empty receive queue, clears with either bit value, a clear that coincides with a new error, and ignored serial-side strobes.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  // Illegal host access classification, shared by top and bench-facing notes
  function automatic logic host_illegal(input logic wr, input logic full,
                                        input logic rd, input logic empty);
    return (wr && full) || (rd && empty);
  endfunction
endpackage

// File: rtl/fdp_fifo.sv
module fdp_fifo #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          full,
  output logic          empty,
  output logic          push_ok,
  output logic          pop_ok
);
  localparam int DEPTH = 1 << AW;
  typedef logic [AW:0] ptr_t;

  function automatic ptr_t ptr_count(input ptr_t w, input ptr_t r);
    return w - r;
  endfunction

  function automatic logic ptr_is_full(input ptr_t w, input ptr_t r);
    return (w[AW] != r[AW]) && (w[AW-1:0] == r[AW-1:0]);
  endfunction

  function automatic logic ptr_is_empty(input ptr_t w, input ptr_t r);
    return w == r;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  ptr_t wptr, rptr;
  ptr_t cnt;

  assign full    = ptr_is_full(wptr, rptr);
  assign empty   = ptr_is_empty(wptr, rptr);
  assign cnt     = ptr_count(wptr, rptr);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push_ok) wptr <= wptr + ptr_t'(1);
      if (pop_ok)  rptr <= rptr + ptr_t'(1);
    end
  end

  AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) (push && full) |=> (wptr == $past(wptr))); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (pop && empty) |=> (rptr == $past(rptr))); // R4
  AST_COUNT_RANGE:  assert property (@(posedge clk) disable iff (!rst_n) cnt <= ptr_t'(DEPTH)); // R7
  AST_FLAGS_EXCL:   assert property (@(posedge clk) disable iff (!rst_n) !(full && empty)); // R7
  AST_BOTH_KEEP:    assert property (@(posedge clk) disable iff (!rst_n) (push_ok && pop_ok) |=> (cnt == $past(cnt))); // R8
endmodule

// File: rtl/fdp_err.sv
module fdp_err (
  input  logic clk,
  input  logic rst_n,
  input  logic illegal,
  input  logic clr_wr,
  input  logic clr_bit,
  output logic pulse,
  output logic flag
);
  logic clr_req;
  assign clr_req = clr_wr && clr_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse <= 1'b0;
      flag  <= 1'b0;
    end else begin
      pulse <= illegal;
      if (illegal)      flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;
    end
  end

  AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) pulse |-> flag); // R6
  AST_FLAG_STICKY:     assert property (@(posedge clk) disable iff (!rst_n) (flag && !clr_req) |=> flag); // R6
  AST_PULSE_ONE:       assert property (@(posedge clk) disable iff (!rst_n) (pulse && !$past(illegal, 2)) |=> !pulse || $past(illegal)); // R5
endmodule

// File: rtl/fifo_data_port.sv
module fifo_data_port #(
  parameter int DATA_W = fdp_pkg::DATA_W,
  parameter int ADDR_W = fdp_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [DATA_W-1:0] host_wr_data,
  input  logic              host_rd_en,
  output logic [DATA_W-1:0] host_rd_data,
  input  logic              err_clr_wr,
  input  logic              err_clr_bit,
  output logic              acc_err_pulse,
  output logic              acc_err_flag,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_full,
  output logic              tx_empty,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              rx_empty
);
  logic              tx_push_ok, tx_pop_ok;
  logic              rx_push_ok, rx_pop_ok;
  logic [DATA_W-1:0] rx_head;
  logic              host_illegal;

  fdp_fifo #(.DW(DATA_W), .AW(ADDR_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .push(host_wr_en), .wdata(host_wr_data),
    .pop(tx_pop), .rdata(tx_data),
    .full(tx_full), .empty(tx_empty),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  fdp_fifo #(.DW(DATA_W), .AW(ADDR_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .wdata(rx_data),
    .pop(host_rd_en), .rdata(rx_head),
    .full(rx_full), .empty(rx_empty),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  assign host_illegal = fdp_pkg::host_illegal(host_wr_en, tx_full, host_rd_en, rx_empty);

  always_ff @(posedge clk) begin
    if (!rst_n)         host_rd_data <= '0;
    else if (rx_pop_ok) host_rd_data <= rx_head;
  end

  fdp_err u_err (
    .clk(clk), .rst_n(rst_n),
    .illegal(host_illegal),
    .clr_wr(err_clr_wr), .clr_bit(err_clr_bit),
    .pulse(acc_err_pulse), .flag(acc_err_flag)
  );

  AST_RDATA_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) (host_rd_en && rx_empty) |=> $stable(host_rd_data)); // R4
  AST_ERR_ON_BAD:  assert property (@(posedge clk) disable iff (!rst_n) (host_wr_en && tx_full) |=> acc_err_pulse); // R5
  AST_BUS_NO_ERR:  assert property (@(posedge clk) disable iff (!rst_n) (!host_wr_en && !host_rd_en) |=> !acc_err_pulse); // R9
  AST_TX_TAKEN:    assert property (@(posedge clk) disable iff (!rst_n) (tx_push_ok && !tx_pop_ok) |=> !tx_empty); // R1
  AST_RX_TAKEN:    assert property (@(posedge clk) disable iff (!rst_n) (rx_push_ok && !rx_pop_ok) |=> !rx_empty); // R3
endmodule

// File: tb/sim_fifo_data_port.sv
module sim_fifo_data_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_wr_en, host_rd_en, err_clr_wr, err_clr_bit, tx_pop, rx_push;
  logic [7:0] host_wr_data, rx_data;
  logic [7:0] host_rd_data, tx_data;
  logic       acc_err_pulse, acc_err_flag, tx_full, tx_empty, rx_full, rx_empty;

  int tests = 0;
  int fails = 0;

  byte unsigned txq[$];
  byte unsigned rxq[$];
  logic [7:0]   exp_rd;
  logic         exp_pulse, exp_flag;

  always #5 clk = ~clk;

  fifo_data_port u0 (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
    .err_clr_wr(err_clr_wr), .err_clr_bit(err_clr_bit),
    .acc_err_pulse(acc_err_pulse), .acc_err_flag(acc_err_flag),
    .tx_pop(tx_pop), .tx_data(tx_data), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_push(rx_push), .rx_data(rx_data), .rx_full(rx_full), .rx_empty(rx_empty)
  );

  function automatic logic mdl_illegal(logic wr, logic rd);
    return (wr && txq.size() == 8) || (rd && rxq.size() == 0);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R7", "tx_full",  tx_full,  txq.size() == 8);
    chk("R7", "tx_empty", tx_empty, txq.size() == 0);
    chk("R7", "rx_full",  rx_full,  rxq.size() == 8);
    chk("R7", "rx_empty", rx_empty, rxq.size() == 0);
    if (txq.size() > 0) chk("R1", "tx_data", tx_data, txq[0]);
    chk("R3", "host_rd_data", host_rd_data, exp_rd);
    chk("R5", "acc_err_pulse", acc_err_pulse, exp_pulse);
    chk("R6", "acc_err_flag", acc_err_flag, exp_flag);
  endtask

  // One cycle: check state of previous edge, then drive and predict the next
  task automatic step(logic wr, logic [7:0] wd, logic rd, logic clr, logic cb,
                      logic tp, logic rp, logic [7:0] rd_in);
    logic ill, wr_ok, tp_ok, rp_ok, rd_ok;
    @(negedge clk);
    check_all();
    host_wr_en = wr; host_wr_data = wd; host_rd_en = rd;
    err_clr_wr = clr; err_clr_bit = cb; tx_pop = tp; rx_push = rp; rx_data = rd_in;
    ill   = mdl_illegal(wr, rd);
    wr_ok = wr && txq.size() < 8;
    tp_ok = tp && txq.size() > 0;
    rp_ok = rp && rxq.size() < 8;
    rd_ok = rd && rxq.size() > 0;
    if (tp_ok) void'(txq.pop_front());
    if (wr_ok) txq.push_back(wd);
    if (rd_ok) exp_rd = rxq.pop_front();
    if (rp_ok) rxq.push_back(rd_in);
    exp_pulse = ill;
    if (ill) exp_flag = 1'b1;
    else if (clr && cb) exp_flag = 1'b0;
  endtask

  task automatic idle();
    step(0, 8'h00, 0, 0, 0, 0, 0, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0;
    host_wr_en = 0; host_wr_data = 0; host_rd_en = 0; err_clr_wr = 0;
    err_clr_bit = 0; tx_pop = 0; rx_push = 0; rx_data = 0;
    exp_rd = 8'h00; exp_pulse = 0; exp_flag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // Reset state: R7 empty flags, R4 read data 0x00, R6 flag 0
    idle();

    // R1, R2: fill transmit queue, then one write more is dropped
    for (int i = 0; i < 9; i++) step(1, 8'hA0 + 8'(i), 0, 0, 0, 0, 0, 8'h00);
    idle(); // R5 pulse from overflow, R6 flag set
    // R6: clear with bit 0 has no effect
    step(0, 0, 0, 1, 0, 0, 0, 0);
    idle();
    // R6: clear with bit 1 clears
    step(0, 0, 0, 1, 1, 0, 0, 0);
    idle();
    // R2: drain and compare order, the dropped byte never appears
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 1, 0, 0);
    // R9: pop of empty transmit queue ignored, no error
    step(0, 0, 0, 0, 0, 1, 0, 0);
    idle();

    // R3, R4: one byte in, read it, then read empty twice
    step(0, 0, 0, 0, 0, 0, 1, 8'h5C);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    idle();
    // R6: error in same cycle as clear keeps flag set; R5 both illegal -> one pulse
    for (int i = 0; i < 8; i++) step(1, 8'h30 + 8'(i), 0, 0, 0, 0, 0, 0);
    step(1, 8'hFF, 1, 1, 1, 0, 0, 0);
    idle();
    idle();
    // R9: push to full receive queue ignored, no error
    for (int i = 0; i < 9; i++) step(0, 0, 0, 0, 0, 0, 1, 8'h70 + 8'(i));
    idle();
    // R8: simultaneous legal push and pop on both queues
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 6; i++) step(1, 8'hC0 + 8'(i), 1, 0, 0, 1, 1, 8'hD0 + 8'(i));
    idle();

    // Random phases with shifting bias (R1..R9)
    for (int ph = 0; ph < 4; ph++) begin
      int pw, pr, pt, pp;
      pw = (ph == 0) ? 70 : (ph == 1) ? 20 : 50;
      pt = (ph == 0) ? 20 : (ph == 1) ? 70 : 50;
      pp = (ph == 2) ? 75 : 35;
      pr = (ph == 2) ? 20 : (ph == 3) ? 60 : 50;
      for (int c = 0; c < 600; c++) begin
        logic w, r, cl, cb, tp, rp;
        w  = ($urandom % 100) < pw;
        r  = ($urandom % 100) < pr;
        cl = ($urandom % 100) < 10;
        cb = $urandom % 2;
        tp = ($urandom % 100) < pt;
        rp = ($urandom % 100) < pp;
        step(w, 8'($urandom), r, cl, cb, tp, rp, 8'($urandom));
      end
    end
    idle();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule